// File: doc/BRIEF.md
# Dual-Rail Line Code Converter

This block converts between a single-rail bit stream and a dual-rail bipolar line representation. The transmit side takes one data bit per strobe and produces a positive rail and a negative rail. A high on the positive rail is a positive mark, a high on the negative rail is a negative mark, and both rails low is a space. The receive side accepts the two rails, one symbol per strobe, and returns the data bit together with a violation flag.

A two-bit mode input selects one of four codings: plain alternate mark inversion, alternate mark inversion with four-zero substitution, alternate mark inversion with eight-zero substitution, or unencoded single-rail data. The two substituting codings need lookahead, so both directions run through a short symbol buffer. The delay through the block is fixed for each mode. The mode is expected to stay the same between resets.

Both directions have one strobe each, so the two sides can run at independent bit rates. Between strobes all outputs hold their values.

Top module: `line_code_conv`

## Requirements
- R1: The mode input selects the coding as 00 = AMI, 01 = HDB3, 10 = B8ZS, 11 = NRZ. The delay from a strobe that takes in a bit or symbol to the strobe that presents the matching output is 1 strobe in AMI and NRZ, 4 strobes in HDB3 and 8 strobes in B8ZS. Outputs presented before that delay has elapsed are spaces, with zero bit and no error.
- R2: In NRZ mode the encoder copies each data bit to the positive output and holds the negative output low.
- R3: In NRZ mode the decoder returns the positive input as the data bit, ignores the negative input (an unconnected input that reads high included), and never raises the error output.
- R4: In AMI mode the encoder sends each 1 as a mark whose polarity is opposite to the previous mark and each 0 as a space. The reference polarity after reset is negative, so the first mark is positive.
- R5: In HDB3 mode a run of four zeros is replaced by 000V when an odd number of marks has been sent since the last violation, and by B00V when that number is even. B is a mark that follows the alternation rule. V is a mark with the same polarity as the mark before it. The mark count is cleared at each violation and starts at zero after reset.
- R6: In B8ZS mode a run of eight zeros is replaced by 000VB0VB, with B and V taking their polarity from the marks that come before them as in R5.
- R7: In HDB3 and B8ZS modes the decoder recognises the substitution patterns of R5 and R6 and turns them back into zeros without an error. Every other mark decodes as 1.
- R8: In the three bipolar modes the decoder raises the error output for a symbol that has both rails high (this symbol decodes as 1). It also raises the error output for a mark with the same polarity as the previous mark that is not part of a recognised substitution. In AMI mode every such mark is an error.
- R9: During reset all four outputs are low. Outputs change only on a cycle in which their side's strobe is high.
- R10: The encoder never drives both output rails high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 2 | Coding select (00 AMI, 01 HDB3, 10 B8ZS, 11 NRZ) |
| enc_vld | input | 1 | Transmit strobe: one data bit is taken in and one symbol is produced |
| enc_bit | input | 1 | Transmit data bit |
| enc_pos | output | 1 | Transmit positive rail |
| enc_neg | output | 1 | Transmit negative rail |
| dec_vld | input | 1 | Receive strobe: one symbol is taken in and one bit is produced |
| dec_pos | input | 1 | Receive positive rail |
| dec_neg | input | 1 | Receive negative rail |
| dec_bit | output | 1 | Decoded data bit |
| dec_err | output | 1 | Violation flag for the decoded bit |

## Verification
The assertions check on every cycle that the rails are exclusive, that the outputs hold between strobes, that the NRZ negative output stays low and the NRZ error stays clear, and that the HDB3 zero-run count never reaches four. Only the bench's scenarios can show the actual polarity sequences, which substitution is chosen by the mark parity, the fixed delay of each mode, and the decoder taking the substitutions back out. The bench covers this with sparse and all-zero streams, dense random data, and an AMI stream with injected violations and both-rails-high symbols.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [1:0] {
    LC_AMI  = 2'b00,
    LC_HDB3 = 2'b01,
    LC_B8ZS = 2'b10,
    LC_NRZ  = 2'b11
  } lc_mode_e;

  // symbol kinds held in the encoder lookahead buffer
  typedef enum logic [1:0] {
    SY_ZERO = 2'b00,
    SY_BIP  = 2'b01,
    SY_VIO  = 2'b10
  } sym_e;

  localparam int HDB3_SPAN = 4;
  localparam int B8ZS_SPAN = 8;
  localparam int BUF_DEPTH = B8ZS_SPAN;

  // buffer slot that leaves the block on a strobe
  function automatic int exit_tap(lc_mode_e m);
    case (m)
      LC_HDB3: exit_tap = HDB3_SPAN - 1;
      LC_B8ZS: exit_tap = B8ZS_SPAN - 1;
      default: exit_tap = 0;
    endcase
  endfunction

endpackage

// File: rtl/lcc_rst_sync.sv
module lcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lcc_enc.sv
module lcc_enc
  import lcc_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lc_mode_e mode,
  input  logic     vld,
  input  logic     bit_in,
  output logic     pos_o,
  output logic     neg_o
);
  localparam int ZW = $clog2(DEPTH + 1);

  sym_e          sbuf_q [DEPTH];
  sym_e          sbuf_d [DEPTH];
  logic [ZW-1:0] zrun_q, zrun_d;
  logic          odd_q, odd_d;
  logic          lastneg_q, lastneg_d;
  logic          pos_q, pos_d;
  logic          neg_q, neg_d;
  sym_e          exit_sym;

  assign exit_sym = sbuf_q[exit_tap(mode)];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) sbuf_d[i] = sbuf_q[i];
    zrun_d    = zrun_q;
    odd_d     = odd_q;
    lastneg_d = lastneg_q;
    pos_d     = pos_q;
    neg_d     = neg_q;
    if (vld) begin
      // output side: give the leaving symbol its polarity
      if (mode == LC_NRZ) begin
        pos_d = (exit_sym != SY_ZERO);
        neg_d = 1'b0;
      end else begin
        case (exit_sym)
          SY_BIP: begin
            pos_d     = lastneg_q;
            neg_d     = ~lastneg_q;
            lastneg_d = ~lastneg_q;
          end
          SY_VIO: begin
            pos_d = ~lastneg_q;
            neg_d = lastneg_q;
          end
          default: begin
            pos_d = 1'b0;
            neg_d = 1'b0;
          end
        endcase
      end
      // input side: shift the new bit in
      sbuf_d[0] = bit_in ? SY_BIP : SY_ZERO;
      for (int i = 1; i < DEPTH; i++) sbuf_d[i] = sbuf_q[i-1];
      if (bit_in) begin
        zrun_d = '0;
        odd_d  = ~odd_q;
      end else if (zrun_q != ZW'(DEPTH)) begin
        zrun_d = zrun_q + 1'b1;
      end
      // zero substitution on the buffered run
      if (mode == LC_HDB3 && !bit_in && zrun_q == ZW'(HDB3_SPAN - 1)) begin
        sbuf_d[0] = SY_VIO;
        if (!odd_q) sbuf_d[HDB3_SPAN-1] = SY_BIP;
        odd_d  = 1'b0;
        zrun_d = '0;
      end
      if (mode == LC_B8ZS && !bit_in && zrun_q == ZW'(B8ZS_SPAN - 1)) begin
        sbuf_d[0] = SY_BIP;
        sbuf_d[1] = SY_VIO;
        sbuf_d[3] = SY_BIP;
        sbuf_d[4] = SY_VIO;
        zrun_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sbuf_q[i] <= SY_ZERO;
      zrun_q    <= '0;
      odd_q     <= 1'b0;
      lastneg_q <= 1'b1;
      pos_q     <= 1'b0;
      neg_q     <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sbuf_q[i] <= sbuf_d[i];
      zrun_q    <= zrun_d;
      odd_q     <= odd_d;
      lastneg_q <= lastneg_d;
      pos_q     <= pos_d;
      neg_q     <= neg_d;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  // R10
  rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_o && neg_o));

  // R2
  nrz_neg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode == LC_NRZ) |=> !neg_o);

  // R9
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(pos_o) && $stable(neg_o)));

  // R5
  zrun_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode == LC_HDB3 && zrun_q < ZW'(HDB3_SPAN)) |=> (zrun_q < ZW'(HDB3_SPAN)));

endmodule

// File: rtl/lcc_dec.sv
module lcc_dec
  import lcc_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lc_mode_e mode,
  input  logic     vld,
  input  logic     pos_in,
  input  logic     neg_in,
  output logic     bit_o,
  output logic     err_o
);
  // per slot: mark seen, violation pending, both rails high
  logic [DEPTH-1:0] mk_q, mk_d;
  logic [DEPTH-1:0] vf_q, vf_d;
  logic [DEPTH-1:0] db_q, db_d;
  logic             lastneg_q, lastneg_d;
  logic             bit_q, bit_d;
  logic             err_q, err_d;
  logic             new_mk, new_vf, new_db;
  logic             hdb_hit, b8_hit;
  int               tap;

  assign tap = exit_tap(mode);

  always_comb begin
    new_mk = 1'b0;
    new_vf = 1'b0;
    new_db = 1'b0;
    if (mode == LC_NRZ) begin
      new_mk = pos_in;
    end else begin
      new_mk = pos_in | neg_in;
      new_db = pos_in & neg_in;
      new_vf = (pos_in ^ neg_in) && (neg_in == lastneg_q);
    end
  end

  always_comb begin
    mk_d      = mk_q;
    vf_d      = vf_q;
    db_d      = db_q;
    lastneg_d = lastneg_q;
    bit_d     = bit_q;
    err_d     = err_q;
    hdb_hit   = 1'b0;
    b8_hit    = 1'b0;
    if (vld) begin
      bit_d = mk_q[tap];
      err_d = (mode != LC_NRZ) && (vf_q[tap] || db_q[tap]);
      if (mode != LC_NRZ && (pos_in ^ neg_in)) lastneg_d = neg_in;
      mk_d = {mk_q[DEPTH-2:0], new_mk};
      vf_d = {vf_q[DEPTH-2:0], new_vf};
      db_d = {db_q[DEPTH-2:0], new_db};
      // 000V or B00V ending in the new symbol
      hdb_hit = (mode == LC_HDB3) && new_vf && !mk_d[1] && !mk_d[2]
                && !vf_d[HDB3_SPAN-1] && !db_d[HDB3_SPAN-1];
      // 000VB0VB ending in the new symbol
      b8_hit = (mode == LC_B8ZS)
               && !mk_d[7] && !mk_d[6] && !mk_d[5]
               && mk_d[4] && vf_d[4] && !db_d[4]
               && mk_d[3] && !vf_d[3] && !db_d[3]
               && !mk_d[2]
               && mk_d[1] && vf_d[1] && !db_d[1]
               && mk_d[0] && !vf_d[0] && !db_d[0];
      if (hdb_hit) begin
        mk_d[HDB3_SPAN-1:0] = '0;
        vf_d[HDB3_SPAN-1:0] = '0;
      end
      if (b8_hit) begin
        mk_d[B8ZS_SPAN-1:0] = '0;
        vf_d[B8ZS_SPAN-1:0] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q      <= '0;
      vf_q      <= '0;
      db_q      <= '0;
      lastneg_q <= 1'b1;
      bit_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      mk_q      <= mk_d;
      vf_q      <= vf_d;
      db_q      <= db_d;
      lastneg_q <= lastneg_d;
      bit_q     <= bit_d;
      err_q     <= err_d;
    end
  end

  assign bit_o = bit_q;
  assign err_o = err_q;

  // R3
  nrz_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode == LC_NRZ) |=> !err_o);

  // R9
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(bit_o) && $stable(err_o)));

  // R8
  dbl_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && $past(mode) != LC_NRZ) |-> bit_o);

endmodule

// File: rtl/line_code_conv.sv
module line_code_conv
  import lcc_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       enc_vld,
  input  logic       enc_bit,
  output logic       enc_pos,
  output logic       enc_neg,
  input  logic       dec_vld,
  input  logic       dec_pos,
  input  logic       dec_neg,
  output logic       dec_bit,
  output logic       dec_err
);
  logic     rst_n_s;
  lc_mode_e mode_e;

  assign mode_e = lc_mode_e'(mode);

  lcc_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  lcc_enc #(.DEPTH(DEPTH)) u_enc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .mode  (mode_e),
    .vld   (enc_vld),
    .bit_in(enc_bit),
    .pos_o (enc_pos),
    .neg_o (enc_neg)
  );

  lcc_dec #(.DEPTH(DEPTH)) u_dec (
    .clk   (clk),
    .rst_n (rst_n_s),
    .mode  (mode_e),
    .vld   (dec_vld),
    .pos_in(dec_pos),
    .neg_in(dec_neg),
    .bit_o (dec_bit),
    .err_o (dec_err)
  );
endmodule

// File: tb/tb_line_code_conv.sv
module tb_line_code_conv;
  localparam int MAXL = 320;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       vld;
  logic       enc_bit, dec_pos, dec_neg;
  logic       enc_pos, enc_neg, dec_bit, dec_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int bits[MAXL], ty[MAXL], xpos[MAXL], xneg[MAXL];
  int dp[MAXL], dn[MAXL], xbit[MAXL], xerr[MAXL];

  always #5 clk = ~clk;

  line_code_conv dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .enc_vld(vld), .enc_bit(enc_bit), .enc_pos(enc_pos), .enc_neg(enc_neg),
    .dec_vld(vld), .dec_pos(dec_pos), .dec_neg(dec_neg),
    .dec_bit(dec_bit), .dec_err(dec_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(int m);
    return (m == 1) ? 4 : (m == 2) ? 8 : 1;
  endfunction

  // reference model of the encoder and matching decoder inputs
  task automatic build(int m, int pct);
    int run, pulses, last;
    for (int i = 0; i < MAXL; i++) bits[i] = (int'($urandom % 100) < pct) ? 1 : 0;
    run = 0; pulses = 0;
    for (int i = 0; i < MAXL; i++) begin
      if (bits[i] == 1) begin
        ty[i] = 1; pulses++; run = 0;
      end else begin
        ty[i] = 0; run++;
        if (m == 1 && run == 4) begin
          ty[i] = 2;
          if (pulses % 2 == 0) ty[i-3] = 1;
          pulses = 0; run = 0;
        end
        if (m == 2 && run == 8) begin
          ty[i-4] = 2; ty[i-3] = 1; ty[i-1] = 2; ty[i] = 1;
          run = 0;
        end
      end
    end
    last = -1;
    for (int i = 0; i < MAXL; i++) begin
      int p;
      p = 0;
      if (ty[i] == 1) begin last = -last; p = last; end
      else if (ty[i] == 2) p = last;
      xpos[i] = (p > 0) ? 1 : 0;
      xneg[i] = (p < 0) ? 1 : 0;
      if (m == 3) begin xpos[i] = bits[i]; xneg[i] = 0; end
      dp[i] = xpos[i]; dn[i] = xneg[i];
      if (m == 3) dn[i] = int'($urandom % 2);
      xbit[i] = bits[i]; xerr[i] = 0;
    end
  endtask

  // AMI decoder stimulus with violations and double marks
  task automatic build_err();
    int last, r;
    last = -1;
    for (int i = 0; i < MAXL; i++) begin
      r = int'($urandom % 10);
      dp[i] = (r == 0 || (r >= 1 && r <= 3)) ? 1 : 0;
      dn[i] = (r == 0 || (r >= 4 && r <= 6)) ? 1 : 0;
      xbit[i] = (dp[i] | dn[i]);
      xerr[i] = 0;
      if (dp[i] == 1 && dn[i] == 1) xerr[i] = 1;
      else if (dp[i] == 1) begin xerr[i] = (last == 1) ? 1 : 0; last = 1; end
      else if (dn[i] == 1) begin xerr[i] = (last == -1) ? 1 : 0; last = -1; end
    end
  endtask

  task automatic run_case(int m, int pct, bit errmode, string ereq, string dreq);
    int lat;
    logic hp, hn, hb, he;
    mode = m[1:0]; vld = 1'b0; enc_bit = 1'b0; dec_pos = 1'b0; dec_neg = 1'b0;
    build(m, pct);
    if (errmode) build_err();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "reset enc_pos", int'(enc_pos), 0);
    chk("R9", "reset enc_neg", int'(enc_neg), 0);
    chk("R9", "reset dec_bit", int'(dec_bit), 0);
    chk("R9", "reset dec_err", int'(dec_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    lat = lat_of(m);
    hp = enc_pos; hn = enc_neg; hb = dec_bit; he = dec_err;
    for (int j = 0; j < MAXL; j++) begin
      int idle;
      idle = int'($urandom % 3);
      enc_bit = ($urandom % 2) == 1;
      dec_pos = ($urandom % 2) == 1;
      dec_neg = ($urandom % 2) == 1;
      for (int k = 0; k < idle; k++) begin
        @(posedge clk); @(negedge clk);
        chk("R9", "idle enc rails", int'({enc_pos, enc_neg}), int'({hp, hn}));
        chk("R9", "idle dec outs", int'({dec_bit, dec_err}), int'({hb, he}));
      end
      vld = 1'b1;
      enc_bit = bits[j][0];
      dec_pos = dp[j][0];
      dec_neg = dn[j][0];
      @(posedge clk); @(negedge clk);
      vld = 1'b0;
      chk("R10", "rails exclusive", int'(enc_pos & enc_neg), 0);
      if (j < lat) begin
        chk("R1", "pre-latency enc", int'({enc_pos, enc_neg}), 0);
        chk("R1", "pre-latency dec", int'({dec_bit, dec_err}), 0);
      end else begin
        chk(ereq, "enc_pos", int'(enc_pos), xpos[j-lat]);
        chk(ereq, "enc_neg", int'(enc_neg), xneg[j-lat]);
        chk(dreq, "dec_bit", int'(dec_bit), xbit[j-lat]);
        chk(dreq, "dec_err", int'(dec_err), xerr[j-lat]);
      end
      hp = enc_pos; hn = enc_neg; hb = dec_bit; he = dec_err;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a7c));
    rst_n = 1'b0; mode = 2'b00; vld = 1'b0;
    enc_bit = 1'b0; dec_pos = 1'b0; dec_neg = 1'b0;
    run_case(0, 50, 1'b0, "R4", "R7");  // AMI random round trip
    run_case(1, 15, 1'b0, "R5", "R7");  // HDB3 sparse
    run_case(1, 0,  1'b0, "R5", "R7");  // HDB3 all zeros
    run_case(1, 60, 1'b0, "R5", "R7");  // HDB3 dense
    run_case(2, 12, 1'b0, "R6", "R7");  // B8ZS sparse
    run_case(2, 0,  1'b0, "R6", "R7");  // B8ZS all zeros
    run_case(3, 50, 1'b0, "R2", "R3");  // NRZ, negative input random
    run_case(0, 50, 1'b1, "R4", "R8");  // AMI decode with violations
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule